// File: doc/BRIEF.md
# Data Watchpoint Match Unit

This block watches the data accesses of a processor core against four programmable watchpoints. Each watchpoint is a pair of registers: a control word and an address value. When an access is presented, every enabled watchpoint compares the access against its watched address. A watchpoint can watch selected bytes of one 8-byte granule, or an aligned power-of-two range. It then filters by access type, privilege of the access and security state. It can also require a context match from an external breakpoint.

The access descriptor gives a byte address, a size of 1 to 8 bytes, load and store flags (both set for a swap), the privilege of the access itself, and the security state. Hits are registered, so a hit appears one cycle after its access. The combined debug event is the OR of the registered hits.

Control word bit positions: enable [0], privilege filter [2:1], type filter [4:3], byte select [12:5], hypervisor control [13] (stored only), security filter [15:14], link index [19:16], link flag [20], range mask [28:24]. Bits [31:29] and [23:21] are reserved.

Top module: `wp_match_unit`

## Requirements
- R1: A watchpoint whose enable bit (control bit 0) is 0 never hits. Reset clears every control word and every value register to zero, so no hit can occur until software programs a watchpoint.
- R2: `wp_hit[i]` rises in the cycle after an access with `acc_valid` high matches watchpoint i. It is 0 in the cycle after any cycle with `acc_valid` low. `dbg_event` is high exactly when any bit of `wp_hit` is high.
- R3: The range mask (bits [28:24]) works as follows. For a value m of 3 or more, address bits [m-1:0] are left out of the comparison, the byte select is ignored, and the watchpoint hits if either the first or the last byte of the access lies in the range. A mask of 1 or 2 never hits.
- R4: With a mask of 0, each bit b of the byte select (bits [12:5]) watches the byte at value+b. The watchpoint hits when any byte covered by the access is watched, including accesses that are unaligned, that cross into the granule from the one below, or that are larger or smaller than the watched bytes.
- R5: The type filter (bits [4:3]) works as follows: 01 matches accesses with the load flag set, 10 matches accesses with the store flag set, and 11 matches both. A swap sets both flags. 00 never matches.
- R6: The privilege filter (bits [2:1]) uses the privilege of the access: 01 matches privileged accesses only, 10 unprivileged only, 11 both, and 00 never matches.
- R7: The security filter (bits [15:14]) works as follows: 01 matches non-secure accesses only (`acc_secure`=0), 10 secure only, and 00 or 11 match either state.
- R8: With the link flag (bit 20) set, a hit also requires `bp_ctx[lbn]`, where lbn is the link index in bits [19:16].
- R9: With the link flag clear and a nonzero link index, the watchpoint never hits.
- R10: A control read returns 0 in bits [31:29] and [23:21] and the stored value of every other bit. A value read returns the written address with bits [2:0] cleared. These cleared bits also take no part in matching. `cfg_sel`=0 selects the control word and 1 selects the value register. The pair is chosen by `cfg_idx`.
- R11: An access of size 0 or of more than 8 bytes never hits.
- R12: The watchpoints are independent. One access can set several `wp_hit` bits, and each bit reflects only its own watchpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_idx | input | IDX_W | Watchpoint pair index |
| cfg_sel | input | 1 | 0 selects the control word, 1 selects the value register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| acc_valid | input | 1 | Access presented this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_size | input | 4 | Access size in bytes |
| acc_load | input | 1 | Access reads memory |
| acc_store | input | 1 | Access writes memory |
| acc_priv | input | 1 | Access is made with privileged rights |
| acc_secure | input | 1 | Access is in the secure state |
| bp_ctx | input | 16 | Per-breakpoint context-match flags |
| wp_hit | output | NUM_WP | Registered per-watchpoint hit |
| dbg_event | output | 1 | OR of all hits |

## Verification
The hardest case to reach is an access that matches in only one of the two granules it spans. This happens when an unaligned access starts below the watched granule and its last byte lands on a watched lane. A masked-range access whose start lies outside the range and whose end lies inside is just as hard. The vector table programs single-lane byte selects, such as only byte 0 or only byte 7, and aims accesses one or two bytes across granule and range boundaries. The same vector is also repeated with a lane or a range that is just missed.

// File: rtl/wpm_pkg.sv
package wpm_pkg;

    localparam int CFG_DW   = 32;
    localparam int NUM_LINK = 16;
    localparam int LINK_W   = $clog2(NUM_LINK);

    // Functional fields of one control word (hypervisor bit kept apart)
    typedef struct packed {
        logic [4:0]        rmask;
        logic              link_en;
        logic [LINK_W-1:0] link_idx;
        logic [1:0]        sec_f;
        logic [7:0]        lanes;
        logic [1:0]        type_f;
        logic [1:0]        priv_f;
        logic              en;
    } wp_cfg_t;

endpackage

// File: rtl/wpm_regs.sv
module wpm_regs
    import wpm_pkg::*;
#(
    parameter int NUM_WP = 4,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(NUM_WP)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_wr,
    input  logic [IDX_W-1:0]               cfg_idx,
    input  logic                           cfg_sel,
    input  logic [CFG_DW-1:0]              cfg_wdata,
    output logic [CFG_DW-1:0]              cfg_rdata,
    output wp_cfg_t [NUM_WP-1:0]           cfg_q,
    output logic [NUM_WP-1:0][ADDR_W-1:0]  val_q
);

    logic [NUM_WP-1:0] hyp_q;
    wire unused_wdata = ^{cfg_wdata[31:29], cfg_wdata[23:21], cfg_wdata[2:0]};

    for (genvar i = 0; i < NUM_WP; i++) begin : g_pair
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[i] <= '0;
                val_q[i] <= '0;
                hyp_q[i] <= 1'b0;
            end else if (cfg_wr && cfg_idx == IDX_W'(i)) begin
                if (cfg_sel) begin
                    val_q[i] <= {cfg_wdata[ADDR_W-1:3], 3'b000};
                end else begin
                    cfg_q[i].en       <= cfg_wdata[0];
                    cfg_q[i].priv_f   <= cfg_wdata[2:1];
                    cfg_q[i].type_f   <= cfg_wdata[4:3];
                    cfg_q[i].lanes    <= cfg_wdata[12:5];
                    hyp_q[i]          <= cfg_wdata[13];
                    cfg_q[i].sec_f    <= cfg_wdata[15:14];
                    cfg_q[i].link_idx <= cfg_wdata[19:16];
                    cfg_q[i].link_en  <= cfg_wdata[20];
                    cfg_q[i].rmask    <= cfg_wdata[28:24];
                end
            end
        end
    end

    always_comb begin
        if (cfg_sel) begin
            cfg_rdata = CFG_DW'(val_q[cfg_idx]);
        end else begin
            cfg_rdata = {3'b000, cfg_q[cfg_idx].rmask, 3'b000,
                         cfg_q[cfg_idx].link_en, cfg_q[cfg_idx].link_idx,
                         cfg_q[cfg_idx].sec_f, hyp_q[cfg_idx],
                         cfg_q[cfg_idx].lanes, cfg_q[cfg_idx].type_f,
                         cfg_q[cfg_idx].priv_f, cfg_q[cfg_idx].en};
        end
    end

endmodule

// File: rtl/wpm_match.sv
module wpm_match
    import wpm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  wp_cfg_t              cfg,
    input  logic [ADDR_W-1:0]    val,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [3:0]           acc_size,
    input  logic                 acc_load,
    input  logic                 acc_store,
    input  logic                 acc_priv,
    input  logic                 acc_secure,
    input  logic [NUM_LINK-1:0]  link_ctx,
    output logic                 hit
);

    localparam int GW = ADDR_W - 3;

    logic              size_ok;
    logic [15:0]       span;
    logic [15:0]       touched;
    logic [GW-1:0]     gran_lo;
    logic [GW-1:0]     gran_hi;
    logic [GW-1:0]     gran_w;
    logic              lane_hit;
    logic [ADDR_W-1:0] last_addr;
    logic              range_hit;
    logic              addr_hit;
    logic              type_ok;
    logic              priv_ok;
    logic              sec_ok;
    logic              link_ok;

    always_comb begin
        size_ok  = (acc_size != 4'd0) && (acc_size <= 4'd8);
        span     = (16'h0001 << acc_size) - 16'h0001;
        touched  = span << acc_addr[2:0];
        gran_lo  = acc_addr[ADDR_W-1:3];
        gran_hi  = gran_lo + GW'(1);
        gran_w   = val[ADDR_W-1:3];
        lane_hit = ((gran_lo == gran_w) && |(touched[7:0]  & cfg.lanes)) ||
                   ((gran_hi == gran_w) && |(touched[15:8] & cfg.lanes));

        last_addr = acc_addr + ADDR_W'(acc_size) - ADDR_W'(1);
        range_hit = ((acc_addr  >> cfg.rmask) == (val >> cfg.rmask)) ||
                    ((last_addr >> cfg.rmask) == (val >> cfg.rmask));

        if (cfg.rmask == 5'd0)      addr_hit = lane_hit;
        else if (cfg.rmask < 5'd3)  addr_hit = 1'b0;
        else                        addr_hit = range_hit;

        type_ok = (cfg.type_f[0] & acc_load) | (cfg.type_f[1] & acc_store);
        priv_ok = acc_priv ? cfg.priv_f[0] : cfg.priv_f[1];

        unique case (cfg.sec_f)
            2'b01:   sec_ok = !acc_secure;
            2'b10:   sec_ok = acc_secure;
            default: sec_ok = 1'b1;
        endcase

        link_ok = cfg.link_en ? link_ctx[cfg.link_idx] : (cfg.link_idx == '0);

        hit = cfg.en & size_ok & addr_hit & type_ok & priv_ok & sec_ok & link_ok;
    end

endmodule

// File: rtl/wp_match_unit.sv
module wp_match_unit
    import wpm_pkg::*;
#(
    parameter int NUM_WP = 4,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(NUM_WP)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic                 cfg_sel,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic                 acc_valid,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [3:0]           acc_size,
    input  logic                 acc_load,
    input  logic                 acc_store,
    input  logic                 acc_priv,
    input  logic                 acc_secure,
    input  logic [15:0]          bp_ctx,
    output logic [NUM_WP-1:0]    wp_hit,
    output logic                 dbg_event
);

    wp_cfg_t [NUM_WP-1:0]          cfg_q;
    logic [NUM_WP-1:0][ADDR_W-1:0] val_q;
    logic [NUM_WP-1:0]             hit_d;
    logic [NUM_WP-1:0]             en_vec;

    wpm_regs #(.NUM_WP(NUM_WP), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_idx   (cfg_idx),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_q     (cfg_q),
        .val_q     (val_q)
    );

    for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
        assign en_vec[i] = cfg_q[i].en;

        wpm_match #(.ADDR_W(ADDR_W)) u_match (
            .cfg        (cfg_q[i]),
            .val        (val_q[i]),
            .acc_addr   (acc_addr),
            .acc_size   (acc_size),
            .acc_load   (acc_load),
            .acc_store  (acc_store),
            .acc_priv   (acc_priv),
            .acc_secure (acc_secure),
            .link_ctx   (bp_ctx),
            .hit        (hit_d[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wp_hit <= '0;
        else        wp_hit <= acc_valid ? hit_d : '0;
    end

    assign dbg_event = |wp_hit;

endmodule

// File: rtl/wpm_checker.sv
module wpm_checker #(
    parameter int NUM_WP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_load,
    input logic              acc_store,
    input logic [3:0]        acc_size,
    input logic              cfg_sel,
    input logic [31:0]       cfg_rdata,
    input logic [NUM_WP-1:0] en_vec,
    input logic [NUM_WP-1:0] wp_hit,
    input logic              dbg_event
);

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (wp_hit & ~$past(en_vec)) == '0); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !$past(acc_valid) |-> wp_hit == '0); // R2
    AST_EVENT_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) dbg_event |-> $past(acc_valid)); // R2
    AST_UNTYPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (!$past(acc_load) && !$past(acc_store)) |-> wp_hit == '0); // R5
    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !cfg_sel |-> (cfg_rdata[31:29] == 3'b000 && cfg_rdata[23:21] == 3'b000)); // R10
    AST_VALUE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) cfg_sel |-> cfg_rdata[2:0] == 3'b000); // R10
    AST_BAD_SIZE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) ($past(acc_size) == 4'd0 || $past(acc_size) > 4'd8) |-> wp_hit == '0); // R11

endmodule

bind wp_match_unit wpm_checker #(.NUM_WP(NUM_WP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_load  (acc_load),
    .acc_store (acc_store),
    .acc_size  (acc_size),
    .cfg_sel   (cfg_sel),
    .cfg_rdata (cfg_rdata),
    .en_vec    (en_vec),
    .wp_hit    (wp_hit),
    .dbg_event (dbg_event)
);

// File: tb/wp_match_unit_tb.sv
module wp_match_unit_tb;

    localparam int NUM_WP = 4;
    localparam int ADDR_W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [3:0]  acc_size = '0;
    logic        acc_load = 1'b0;
    logic        acc_store = 1'b0;
    logic        acc_priv = 1'b0;
    logic        acc_secure = 1'b0;
    logic [15:0] bp_ctx = '0;
    logic [3:0]  wp_hit;
    logic        dbg_event;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wp_match_unit #(.NUM_WP(NUM_WP), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
        .acc_load(acc_load), .acc_store(acc_store), .acc_priv(acc_priv),
        .acc_secure(acc_secure), .bp_ctx(bp_ctx), .wp_hit(wp_hit),
        .dbg_event(dbg_event)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [31:0] ctrl;
        logic [31:0] val;
        logic [31:0] addr;
        logic [3:0]  size;
        logic        ld, st, pr, sec;
        logic [15:0] ctx;
        logic        exp;
    } vec_t;

    function automatic logic [31:0] cw(int e, int pac, int lsc, int bas, int ssc,
                                       int lbn, int wt, int msk);
        return {3'b000, 5'(msk), 3'b000, 1'(wt), 4'(lbn), 2'(ssc), 1'b0,
                8'(bas), 2'(lsc), 2'(pac), 1'(e)};
    endfunction

    function automatic vec_t v(int req, int e, int pac, int lsc, int bas, int ssc,
                               int lbn, int wt, int msk, int val, int addr, int size,
                               int ld, int st, int pr, int sec, int ctx, int exp);
        vec_t r;
        r.req  = 8'(req);
        r.ctrl = cw(e, pac, lsc, bas, ssc, lbn, wt, msk);
        r.val  = 32'(val);
        r.addr = 32'(addr);
        r.size = 4'(size);
        r.ld   = 1'(ld);
        r.st   = 1'(st);
        r.pr   = 1'(pr);
        r.sec  = 1'(sec);
        r.ctx  = 16'(ctx);
        r.exp  = 1'(exp);
        return r;
    endfunction

    localparam int NV = 38;
    localparam vec_t VECS [NV] = '{
        //  req e pac lsc bas    ssc lbn wt msk val      addr     sz ld st pr sec ctx      exp
        v(4,  1, 3, 3, 'hFF, 0, 0, 0, 0,  'h1000, 'h1000, 4, 1, 0, 1, 0, 0,       1), // R4 plain hit
        v(1,  0, 3, 3, 'hFF, 0, 0, 0, 0,  'h1000, 'h1000, 4, 1, 0, 1, 0, 0,       0), // R1 disabled
        v(4,  1, 3, 3, 'h01, 0, 0, 0, 0,  'h1000, 'h1001, 1, 1, 0, 1, 0, 0,       0), // R4 unwatched lane
        v(4,  1, 3, 3, 'h01, 0, 0, 0, 0,  'h1000, 'h0FFF, 2, 1, 0, 1, 0, 0,       1), // R4 crosses in from below
        v(4,  1, 3, 3, 'h80, 0, 0, 0, 0,  'h1000, 'h1000, 8, 1, 0, 1, 0, 0,       1), // R4 larger access
        v(4,  1, 3, 3, 'h80, 0, 0, 0, 0,  'h1000, 'h1000, 4, 1, 0, 1, 0, 0,       0), // R4 misses lane 7
        v(4,  1, 3, 3, 'h0C, 0, 0, 0, 0,  'h1000, 'h1003, 1, 1, 0, 1, 0, 0,       1), // R4 smaller access
        v(4,  1, 3, 3, 'hFF, 0, 0, 0, 0,  'h1000, 'h1008, 4, 1, 0, 1, 0, 0,       0), // R4 next granule
        v(10, 1, 3, 3, 'h01, 0, 0, 0, 0,  'h1005, 'h1000, 1, 1, 0, 1, 0, 0,       1), // R10 low value bits dropped
        v(5,  1, 3, 1, 'hFF, 0, 0, 0, 0,  'h1000, 'h1000, 4, 0, 1, 1, 0, 0,       0), // R5 loads only, store
        v(5,  1, 3, 1, 'hFF, 0, 0, 0, 0,  'h1000, 'h1000, 4, 1, 0, 1, 0, 0,       1), // R5 loads only, load
        v(5,  1, 3, 2, 'hFF, 0, 0, 0, 0,  'h1000, 'h1000, 4, 0, 1, 1, 0, 0,       1), // R5 stores only, store
        v(5,  1, 3, 2, 'hFF, 0, 0, 0, 0,  'h1000, 'h1000, 4, 1, 0, 1, 0, 0,       0), // R5 stores only, load
        v(5,  1, 3, 0, 'hFF, 0, 0, 0, 0,  'h1000, 'h1000, 4, 1, 1, 1, 0, 0,       0), // R5 type 00
        v(5,  1, 3, 1, 'hFF, 0, 0, 0, 0,  'h1000, 'h1000, 4, 1, 1, 1, 0, 0,       1), // R5 swap on loads
        v(6,  1, 1, 3, 'hFF, 0, 0, 0, 0,  'h1000, 'h1000, 4, 1, 0, 0, 0, 0,       0), // R6 priv-only, user access
        v(6,  1, 1, 3, 'hFF, 0, 0, 0, 0,  'h1000, 'h1000, 4, 1, 0, 1, 0, 0,       1), // R6 priv-only, priv access
        v(6,  1, 2, 3, 'hFF, 0, 0, 0, 0,  'h1000, 'h1000, 4, 1, 0, 1, 0, 0,       0), // R6 user-only, priv access
        v(6,  1, 2, 3, 'hFF, 0, 0, 0, 0,  'h1000, 'h1000, 4, 1, 0, 0, 0, 0,       1), // R6 user-only, user access
        v(6,  1, 0, 3, 'hFF, 0, 0, 0, 0,  'h1000, 'h1000, 4, 1, 0, 1, 0, 0,       0), // R6 filter 00
        v(7,  1, 3, 3, 'hFF, 1, 0, 0, 0,  'h1000, 'h1000, 4, 1, 0, 1, 1, 0,       0), // R7 non-secure only, secure
        v(7,  1, 3, 3, 'hFF, 1, 0, 0, 0,  'h1000, 'h1000, 4, 1, 0, 1, 0, 0,       1), // R7 non-secure only, ns
        v(7,  1, 3, 3, 'hFF, 2, 0, 0, 0,  'h1000, 'h1000, 4, 1, 0, 1, 0, 0,       0), // R7 secure only, ns
        v(7,  1, 3, 3, 'hFF, 2, 0, 0, 0,  'h1000, 'h1000, 4, 1, 0, 1, 1, 0,       1), // R7 secure only, secure
        v(8,  1, 3, 3, 'hFF, 0, 5, 1, 0,  'h1000, 'h1000, 4, 1, 0, 1, 0, 0,       0), // R8 link, no context
        v(8,  1, 3, 3, 'hFF, 0, 5, 1, 0,  'h1000, 'h1000, 4, 1, 0, 1, 0, 'h0020,  1), // R8 link, context 5
        v(8,  1, 3, 3, 'hFF, 0, 5, 1, 0,  'h1000, 'h1000, 4, 1, 0, 1, 0, 'hFFDF,  0), // R8 link, other contexts
        v(9,  1, 3, 3, 'hFF, 0, 3, 0, 0,  'h1000, 'h1000, 4, 1, 0, 1, 0, 'hFFFF,  0), // R9 unlinked, index set
        v(3,  1, 3, 3, 'h00, 0, 0, 0, 12, 'h5000, 'h5FFC, 4, 1, 0, 1, 0, 0,       1), // R3 top of range
        v(3,  1, 3, 3, 'h00, 0, 0, 0, 12, 'h5000, 'h6000, 4, 1, 0, 1, 0, 0,       0), // R3 past range
        v(3,  1, 3, 3, 'h00, 0, 0, 0, 12, 'h5000, 'h4FFE, 4, 1, 0, 1, 0, 0,       1), // R3 end inside range
        v(3,  1, 3, 3, 'h00, 0, 0, 0, 12, 'h5123, 'h5ABC, 1, 1, 0, 1, 0, 0,       1), // R3 low value bits masked
        v(3,  1, 3, 3, 'hFF, 0, 0, 0, 1,  'h1000, 'h1000, 4, 1, 0, 1, 0, 0,       0), // R3 reserved mask 1
        v(3,  1, 3, 3, 'hFF, 0, 0, 0, 2,  'h1000, 'h1000, 4, 1, 0, 1, 0, 0,       0), // R3 reserved mask 2
        v(3,  1, 3, 3, 'h00, 0, 0, 0, 3,  'h1000, 'h1007, 1, 1, 0, 1, 0, 0,       1), // R3 smallest range
        v(11, 1, 3, 3, 'hFF, 0, 0, 0, 0,  'h1000, 'h1000, 0, 1, 0, 1, 0, 0,       0), // R11 size 0
        v(11, 1, 3, 3, 'hFF, 0, 0, 0, 0,  'h1000, 'h1000, 9, 1, 0, 1, 0, 0,       0), // R11 size 9
        v(4,  1, 3, 3, 'h80, 0, 0, 0, 0,  'h1000, 'h1007, 1, 1, 0, 1, 0, 0,       1)  // R4 last lane only
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int idx, logic sel, logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = 2'(idx); cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(int idx, logic sel, output logic [31:0] d);
        @(negedge clk);
        cfg_idx = 2'(idx); cfg_sel = sel;
        #1 d = cfg_rdata;
    endtask

    // Drives one access for one cycle; returns at the negedge after the capturing edge
    task automatic acc(logic [31:0] a, logic [3:0] sz, logic ld, logic st,
                       logic pr, logic sec, logic [15:0] ctx);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_load = ld;
        acc_store = st; acc_priv = pr; acc_secure = sec; bp_ctx = ctx;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state: all registers zero, nothing hits
        for (int i = 0; i < NUM_WP; i++) begin
            rd(i, 1'b0, d); chk("R1 reset control", d, 32'h0);
            rd(i, 1'b1, d); chk("R1 reset value", d, 32'h0);
        end
        acc(32'h0, 4'd4, 1'b1, 1'b1, 1'b1, 1'b0, 16'hFFFF);
        chk("R1 no hit after reset", {27'h0, dbg_event, wp_hit}, 32'h0);

        // Vector table on watchpoint 0
        for (int k = 0; k < NV; k++) begin
            wr(0, 1'b0, VECS[k].ctrl);
            wr(0, 1'b1, VECS[k].val);
            acc(VECS[k].addr, VECS[k].size, VECS[k].ld, VECS[k].st,
                VECS[k].pr, VECS[k].sec, VECS[k].ctx);
            n_chk++;
            if (wp_hit !== {3'b000, VECS[k].exp} || dbg_event !== VECS[k].exp) begin
                n_fail++;
                $display("FAIL R%0d vector %0d actual=%b/%b expected=%b/%b",
                         VECS[k].req, k, wp_hit, dbg_event, {3'b000, VECS[k].exp}, VECS[k].exp);
            end
        end
        wr(0, 1'b0, 32'h0);

        // R10 readback of reserved and aligned bits
        wr(1, 1'b0, 32'hFFFF_FFFF);
        wr(1, 1'b1, 32'hFFFF_FFFF);
        rd(1, 1'b0, d); chk("R10 control readback", d, 32'h1F1F_FFFF);
        rd(1, 1'b1, d); chk("R10 value readback", d, 32'hFFFF_FFF8);
        rd(0, 1'b1, d); chk("R10 other pair untouched", d, 32'h0000_1000);

        // R12 independent watchpoints
        wr(1, 1'b0, 32'h0000_1FFF); wr(1, 1'b1, 32'h0000_3000);
        wr(2, 1'b0, 32'h0000_1FFF); wr(2, 1'b1, 32'h0000_2000);
        wr(3, 1'b0, 32'h0000_1FFF); wr(3, 1'b1, 32'h0000_2000);
        acc(32'h2000, 4'd4, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0);
        chk("R12 two watchpoints hit", {27'h0, dbg_event, wp_hit}, {27'h0, 1'b1, 4'b1100});
        acc(32'h3004, 4'd2, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        chk("R12 only pair 1 hits", {27'h0, dbg_event, wp_hit}, {27'h0, 1'b1, 4'b0010});

        // R2 timing: nothing before the edge, a pulse after it, cleared when idle
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'h2000; acc_size = 4'd1;
        acc_load = 1'b1; acc_store = 1'b0; acc_priv = 1'b1; acc_secure = 1'b0;
        #1 chk("R2 no hit before edge", {28'h0, wp_hit}, 32'h0);
        @(negedge clk);
        acc_valid = 1'b0;
        chk("R2 hit one cycle later", {27'h0, dbg_event, wp_hit}, {27'h0, 1'b1, 4'b1100});
        @(negedge clk);
        chk("R2 cleared when idle", {27'h0, dbg_event, wp_hit}, 32'h0);

        // R1 disabling one pair silences it alone
        wr(3, 1'b0, 32'h0000_1FFE);
        acc(32'h2000, 4'd4, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0);
        chk("R1 disabled pair silent", {28'h0, wp_hit}, {28'h0, 4'b0100});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule